// File: doc/BRIEF.md
# Programmable Parallel Display Bus Timing Engine

This block runs single read and write transfers on an asynchronous parallel bus that serves one display device behind a single chip select. A transfer is taken from a valid/ready request port and is played out in three timed phases. First comes a set-up phase, where select, direction, the address-latch line and the data driver settle. Next comes a strobe phase, where the read or write strobe is active. Last comes a hold phase, where everything but the strobe stays asserted. After the hold phase, an idle gap of programmable length separates this transfer from the next.

Every phase length is counted in clock cycles and comes from one 32-bit configuration word. Writes and reads each have their own set-up, strobe and hold fields. The word is sampled once, when a transfer is accepted, so software may rewrite it at any time. Read data is taken from the bus on the final strobe cycle and returned with a one-cycle valid pulse. Two reads in a row run with no idle gap between them.

Top module: `disp_bus_timer`

## Requirements
- R1: After reset, every bus output is deasserted: bus_cs, bus_ale, bus_dir, bus_oe, bus_rd and bus_wr are all 0. With nothing in progress, req_ready is 1.
- R2: The set-up phase lasts exactly the set-up field of the transfer type, in cycles. It begins on the cycle after acceptance. During it, bus_cs and bus_ale are 1 and the strobes are 0. The write set-up field is cfg_word[31:27] and the read set-up field is cfg_word[16:12]. A value of 0 removes the phase, so the strobe begins on the cycle after acceptance.
- R3: The strobe is active for exactly the strobe field of the transfer type, in cycles, and a field of 0 counts as 1. The write strobe field is cfg_word[26:21] and the read strobe field is cfg_word[11:6].
- R4: After the strobe ends, bus_cs, bus_ale, bus_dir and bus_oe keep their values for exactly the hold field, in cycles, and a field of 0 counts as 1. The write hold field is cfg_word[20:17] and the read hold field is cfg_word[5:2].
- R5: Two consecutive transfers, when the later one is not a read following a read, are separated by exactly gap+1 cycles with bus_cs at 0. Here gap is cfg_word[1:0] as latched for the earlier transfer.
- R6: When a read is requested while a read is in its last hold cycle, the new read starts at once. bus_cs stays 1 between the two reads.
- R7: A transfer with req_write=1 uses only the write fields and drives bus_wr. A transfer with req_write=0 uses only the read fields and drives bus_rd. The two strobes are never active together.
- R8: rd_data takes the value of bus_din from the last cycle of the read strobe. rd_valid is 1 for exactly one cycle per read, on the cycle that follows that strobe cycle.
- R9: During a write, bus_dir and bus_oe are 1 for the whole time bus_cs is 1, and bus_dout carries the accepted req_wdata. During a read, bus_dir and bus_oe stay 0.
- R10: The configuration word is latched when a transfer is accepted. Changing cfg_word while a transfer runs does not change that transfer's timing.
- R11: req_ready is 0 from acceptance until the last gap cycle. After a read, it is also 1 in the last hold cycle, but only when the pending request is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; all phase counts use it |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A transfer request is offered |
| req_ready | output | 1 | Request is accepted on this cycle's rising edge when valid |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| req_wdata | input | DATA_W | Data to write |
| cfg_word | input | 32 | Phase-length configuration, sampled at acceptance |
| bus_cs | output | 1 | Chip select, active high |
| bus_ale | output | 1 | Address-latch line, follows the select |
| bus_dir | output | 1 | Direction, 1 while a write is on the bus |
| bus_oe | output | 1 | Data driver enable toward the device |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_dout | output | DATA_W | Write data toward the device |
| bus_din | input | DATA_W | Read data from the device |
| rd_data | output | DATA_W | Captured read data |
| rd_valid | output | 1 | One-cycle pulse when rd_data is new |

## Verification
The bench uses the default DATA_W of 16 and the fixed 6-bit phase counter that the field layout implies. At these widths, every field can be driven to both of its ends: zero strobe and hold fields, which must stretch to one cycle, and the largest set-up, strobe and hold values of 31, 63 and 15. Transfers are chained with the request held valid, so every turnaround value and the read-after-read bypass appear at exact cycle counts. The bus_din value changes on every cycle, so a capture that is one cycle early or late shows up as a mismatch.

// File: rtl/disp_bus_pkg.sv
package disp_bus_pkg;

  localparam int CFG_W  = 32;
  localparam int CNT_W  = 6;

  localparam int WSU_HI = 31, WSU_LO = 27;
  localparam int WST_HI = 26, WST_LO = 21;
  localparam int WHD_HI = 20, WHD_LO = 17;
  localparam int RSU_HI = 16, RSU_LO = 12;
  localparam int RST_HI = 11, RST_LO = 6;
  localparam int RHD_HI = 5,  RHD_LO = 2;
  localparam int GAP_HI = 1,  GAP_LO = 0;

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_TURN   = 3'd4
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] su;
    logic [CNT_W-1:0] st;
    logic [CNT_W-1:0] hd;
    logic [CNT_W-1:0] gap;
  } plen_t;

  function automatic logic [CNT_W-1:0] floor_one(input logic [CNT_W-1:0] v);
    return (v == CNT_ZERO) ? CNT_ONE : v;
  endfunction

  function automatic plen_t pick_lengths(input logic [CFG_W-1:0] w, input logic is_wr);
    plen_t r;
    if (is_wr) begin
      r.su = CNT_W'(w[WSU_HI:WSU_LO]);
      r.st = floor_one(CNT_W'(w[WST_HI:WST_LO]));
      r.hd = floor_one(CNT_W'(w[WHD_HI:WHD_LO]));
    end else begin
      r.su = CNT_W'(w[RSU_HI:RSU_LO]);
      r.st = floor_one(CNT_W'(w[RST_HI:RST_LO]));
      r.hd = floor_one(CNT_W'(w[RHD_HI:RHD_LO]));
    end
    r.gap = CNT_W'(w[GAP_HI:GAP_LO]);
    return r;
  endfunction

  function automatic logic on_bus(input phase_e p);
    return (p == PH_SETUP) || (p == PH_STROBE) || (p == PH_HOLD);
  endfunction

endpackage

// File: rtl/disp_cfg_decode.sv
module disp_cfg_decode
  import disp_bus_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             is_wr,
  output plen_t            lens
);

  always_comb lens = pick_lengths(cfg_word, is_wr);

endmodule

// File: rtl/disp_phase_seq.sv
module disp_phase_seq
  import disp_bus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   req_write,
  input  plen_t  in_lens,
  output logic   req_ready,
  output logic   accept,
  output phase_e nxt_phase,
  output logic   nxt_wr,
  output logic   rd_sample
);

  phase_e           phase;
  logic [CNT_W-1:0] cnt, nxt_cnt;
  logic             cur_wr;
  plen_t            cur_lens, nxt_lens;

  logic cnt_done, last_hold, last_turn, last_strobe;

  assign cnt_done    = (cnt == CNT_ZERO);
  assign last_hold   = (phase == PH_HOLD) && cnt_done;
  assign last_turn   = (phase == PH_TURN) && cnt_done;
  assign last_strobe = (phase == PH_STROBE) && cnt_done;

  assign req_ready = (phase == PH_IDLE) || last_turn ||
                     (last_hold && !cur_wr && !req_write);
  assign accept    = req_valid && req_ready;
  assign nxt_wr    = accept ? req_write : cur_wr;
  assign rd_sample = last_strobe && !cur_wr;

  always_comb begin
    nxt_phase = phase;
    nxt_cnt   = cnt;
    nxt_lens  = cur_lens;
    if (accept) begin
      nxt_lens = in_lens;
      if (in_lens.su != CNT_ZERO) begin
        nxt_phase = PH_SETUP;
        nxt_cnt   = in_lens.su - CNT_ONE;
      end else begin
        nxt_phase = PH_STROBE;
        nxt_cnt   = in_lens.st - CNT_ONE;
      end
    end else begin
      unique case (phase)
        PH_SETUP:
          if (cnt_done) begin
            nxt_phase = PH_STROBE;
            nxt_cnt   = cur_lens.st - CNT_ONE;
          end else nxt_cnt = cnt - CNT_ONE;
        PH_STROBE:
          if (cnt_done) begin
            nxt_phase = PH_HOLD;
            nxt_cnt   = cur_lens.hd - CNT_ONE;
          end else nxt_cnt = cnt - CNT_ONE;
        PH_HOLD:
          if (cnt_done) begin
            nxt_phase = PH_TURN;
            nxt_cnt   = cur_lens.gap;
          end else nxt_cnt = cnt - CNT_ONE;
        PH_TURN:
          if (cnt_done) nxt_phase = PH_IDLE;
          else          nxt_cnt   = cnt - CNT_ONE;
        default: nxt_phase = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= CNT_ZERO;
      cur_wr   <= 1'b0;
      cur_lens <= '0;
    end else begin
      phase    <= nxt_phase;
      cnt      <= nxt_cnt;
      cur_wr   <= nxt_wr;
      cur_lens <= nxt_lens;
    end
  end

  // R11: the request port is closed while a strobe is active
  p_closed_in_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STROBE) |-> !req_ready);

  // R4: a strobe is always followed by at least one hold cycle
  p_hold_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last_strobe |=> (phase == PH_HOLD));

  // R5: a finished write always passes through the gap phase
  p_gap_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_hold && cur_wr) |=> (phase == PH_TURN));

  // R10: latched lengths only change when a transfer is accepted
  p_lens_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(accept) && (phase != PH_IDLE)) |-> $stable(cur_lens));

endmodule

// File: rtl/disp_rd_capture.sv
module disp_rd_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= sample;
      if (sample) rd_data <= bus_din;
    end
  end

  // R8: a valid pulse lasts a single cycle
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/disp_bus_timer.sv
module disp_bus_timer
  import disp_bus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CFG_W-1:0]  cfg_word,
  output logic              bus_cs,
  output logic              bus_ale,
  output logic              bus_dir,
  output logic              bus_oe,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  plen_t  req_lens;
  logic   accept, nxt_wr, rd_sample;
  phase_e nxt_phase;
  logic   nxt_on_bus, nxt_strobe;

  disp_cfg_decode u_decode (
    .cfg_word (cfg_word),
    .is_wr    (req_write),
    .lens     (req_lens)
  );

  disp_phase_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .in_lens   (req_lens),
    .req_ready (req_ready),
    .accept    (accept),
    .nxt_phase (nxt_phase),
    .nxt_wr    (nxt_wr),
    .rd_sample (rd_sample)
  );

  disp_rd_capture #(.DATA_W(DATA_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample   (rd_sample),
    .bus_din  (bus_din),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  assign nxt_on_bus = on_bus(nxt_phase);
  assign nxt_strobe = (nxt_phase == PH_STROBE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_cs   <= 1'b0;
      bus_ale  <= 1'b0;
      bus_dir  <= 1'b0;
      bus_oe   <= 1'b0;
      bus_rd   <= 1'b0;
      bus_wr   <= 1'b0;
      bus_dout <= '0;
    end else begin
      bus_cs  <= nxt_on_bus;
      bus_ale <= nxt_on_bus;
      bus_dir <= nxt_on_bus && nxt_wr;
      bus_oe  <= nxt_on_bus && nxt_wr;
      bus_rd  <= nxt_strobe && !nxt_wr;
      bus_wr  <= nxt_strobe && nxt_wr;
      if (accept && req_write) bus_dout <= req_wdata;
    end
  end

  // R7: never both strobes at once
  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  // R1: a strobe only appears inside an active select
  p_strobe_in_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> bus_cs);

  // R9: the data driver is off during a read strobe
  p_rd_no_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (!bus_oe && !bus_dir));

  // R2: an accepted request puts the select on the bus next cycle
  p_accept_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> bus_cs);

  // R4: the select survives the falling strobe
  p_hold_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rd || bus_wr) |-> bus_cs);

endmodule

// File: tb/tb_disp_bus_timer.sv
module tb_disp_bus_timer;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic [31:0]   cfg_word = '0;
  logic          bus_cs, bus_ale, bus_dir, bus_oe, bus_rd, bus_wr;
  logic [DW-1:0] bus_dout;
  logic [DW-1:0] bus_din = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  always #4 clk = ~clk;

  disp_bus_timer #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wdata(req_wdata), .cfg_word(cfg_word),
    .bus_cs(bus_cs), .bus_ale(bus_ale), .bus_dir(bus_dir), .bus_oe(bus_oe),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_dout(bus_dout), .bus_din(bus_din),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct {
    bit      wr;
    int      su, st, hd, gap;
    logic [DW-1:0] data;
  } item_t;

  item_t exp_q[$];

  function automatic logic [31:0] mk_cfg(int wsu, int wst, int whd,
                                         int rsu, int rst, int rhd, int gap);
    return {wsu[4:0], wst[5:0], whd[3:0], rsu[4:0], rst[5:0], rhd[3:0], gap[1:0]};
  endfunction

  function automatic int at_least1(int v);
    return (v < 1) ? 1 : v;
  endfunction

  bit prev_wr = 1'b1;
  int prev_gap = 0;
  int n_rd_sent = 0;

  // driver: offer one request, wait for acceptance, push the expectation
  task automatic send(input bit wr, input logic [DW-1:0] d,
                      input logic [31:0] cfg, input bit chained);
    item_t it;
    req_valid = 1'b1;
    req_write = wr;
    req_wdata = d;
    cfg_word  = cfg;
    while (!req_ready) @(negedge clk);
    it.wr   = wr;
    it.data = d;
    it.su   = wr ? int'(cfg[31:27]) : int'(cfg[16:12]);
    it.st   = at_least1(wr ? int'(cfg[26:21]) : int'(cfg[11:6]));
    it.hd   = at_least1(wr ? int'(cfg[20:17]) : int'(cfg[5:2]));
    if (!chained)           it.gap = -1;
    else if (!prev_wr && !wr) it.gap = 0;
    else                    it.gap = prev_gap + 1;
    exp_q.push_back(it);
    prev_wr  = wr;
    prev_gap = int'(cfg[1:0]);
    if (!wr) n_rd_sent++;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  bit in_acc = 0, seen_stb = 0, bad_dir = 0, bad_rdy = 0, o_dir = 0;
  int o_su, o_st, o_hd, o_gap, gap_cnt = 999;
  logic [DW-1:0] o_data, rd_last;
  int n_rd_seen = 0;

  task automatic finalize();
    item_t e;
    in_acc = 0;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R7 unexpected transfer", 1, 0);
      return;
    end
    e = exp_q.pop_front();
    chk(o_dir == e.wr, "R7 transfer type", int'(o_dir), int'(e.wr));
    chk(o_su == e.su, "R2 setup cycles", o_su, e.su);
    chk(o_st == e.st, "R3 strobe cycles", o_st, e.st);
    chk(o_hd == e.hd, "R4 hold cycles", o_hd, e.hd);
    if (e.gap > 0) chk(o_gap == e.gap, "R5 gap cycles", o_gap, e.gap);
    if (e.gap == 0) chk(o_gap == 0, "R6 read-read no gap", o_gap, 0);
    chk(!bad_dir, "R9 dir/oe level", int'(bad_dir), 0);
    chk(!bad_rdy, "R11 ready low in strobe", int'(bad_rdy), 0);
    if (e.wr) chk(o_data == e.data, "R9 write data", int'(o_data), int'(e.data));
  endtask

  task automatic open_acc(input int g);
    in_acc = 1; seen_stb = 0; bad_dir = 0; bad_rdy = 0;
    o_su = 0; o_st = 0; o_hd = 0; o_gap = g; o_dir = bus_dir; o_data = '0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin
        n_rd_seen++;
        chk(rd_data == rd_last, "R8 read data", int'(rd_data), int'(rd_last));
      end
      if (!bus_cs) begin
        if (in_acc) finalize();
        gap_cnt++;
      end else begin
        if (!in_acc) begin
          open_acc(gap_cnt);
          gap_cnt = 0;
        end else if ((bus_rd || bus_wr) && seen_stb && o_hd > 0) begin
          finalize();
          open_acc(0);
        end
        if (bus_rd || bus_wr) begin
          o_st++;
          seen_stb = 1;
          if (bus_wr) o_data = bus_dout;
          if (req_ready) bad_rdy = 1;
        end else if (seen_stb) o_hd++;
        else o_su++;
        if (bus_dir != o_dir || bus_oe != o_dir || !bus_ale) bad_dir = 1;
      end
      bus_din = bus_din * 16'd5 + 16'd13;
      if (bus_rd) rd_last = bus_din;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk({bus_cs, bus_ale, bus_dir, bus_oe, bus_rd, bus_wr} == 6'b0,
        "R1 outputs idle", int'({bus_cs, bus_ale, bus_dir, bus_oe, bus_rd, bus_wr}), 0);
    chk(req_ready == 1'b1, "R1 ready idle", int'(req_ready), 1);

    // R2 R3 R4 R5 R7: write then chained reads and back to a write
    send(1'b1, 16'hA55A, mk_cfg(3, 4, 2, 2, 3, 2, 1), 1'b0);
    send(1'b0, 16'h0,    mk_cfg(1, 1, 1, 2, 3, 2, 2), 1'b1);
    // R6: read after read, zero set-up so phases stay visible
    send(1'b0, 16'h0,    mk_cfg(1, 1, 1, 0, 2, 3, 3), 1'b1);
    send(1'b0, 16'h0,    mk_cfg(1, 1, 1, 0, 1, 1, 3), 1'b1);
    send(1'b1, 16'h1234, mk_cfg(2, 2, 2, 5, 5, 5, 0), 1'b1);
    send(1'b1, 16'h4321, mk_cfg(0, 3, 1, 5, 5, 5, 2), 1'b1);
    go_idle(30);

    // R3 R4: zero strobe and hold fields count as one cycle
    send(1'b1, 16'h00FF, mk_cfg(0, 0, 0, 0, 0, 0, 0), 1'b0);
    send(1'b0, 16'h0,    mk_cfg(0, 0, 0, 0, 0, 0, 0), 1'b1);
    go_idle(20);

    // field maxima
    send(1'b1, 16'hBEEF, mk_cfg(31, 63, 15, 31, 63, 15, 3), 1'b0);
    send(1'b0, 16'h0,    mk_cfg(31, 63, 15, 31, 63, 15, 3), 1'b1);
    go_idle(200);

    // R10: rewrite the word while a transfer runs
    send(1'b1, 16'h5A5A, mk_cfg(4, 5, 3, 1, 1, 1, 1), 1'b0);
    cfg_word = mk_cfg(31, 63, 15, 31, 63, 15, 3);
    go_idle(5);
    cfg_word = '0;
    go_idle(30);
    chk(exp_q.size() == 0, "R10 pending transfers", exp_q.size(), 0);

    // R11: idle port open again after everything drained
    chk(req_ready == 1'b1, "R11 ready after drain", int'(req_ready), 1);
    chk(n_rd_seen == n_rd_sent, "R8 read pulses", n_rd_seen, n_rd_sent);
    chk(bus_cs == 1'b0, "R1 idle after traffic", int'(bus_cs), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule